// File: doc/BRIEF.md
# Programmable SPI Serial Clock Generator

This block derives an SPI serial clock from one of four root frequencies. A two-bit source code picks the root. A three-bit pre-divider code `p` divides that root by `p+1`, which gives the base frequency `F`. An 8-bit final divisor `N` then sets the output clock to `F/(N+2)`. The root frequencies are parameters in Hz. The SCK waveform itself is produced in cycles of the block's own clock `clk`, with a period of `N+2` cycles of `clk`.

Software-side logic offers a target rate in Hz on a valid/ready request channel. A sequential calculator uses one iterative 32-step divider to work out `F`, then `N`, then the rate actually achieved. `N` is chosen so that SCK is as fast as possible without going above the request. When the request is too slow to reach, `N` saturates at its largest value. A request equal to the previous one is answered from a one-entry cache. Any write to the source or pre-divider clears that cache.

Configuration writes are applied only while SCK is gated off (`sck_en` low) and no calculation is running. A write that arrives outside that window is held until the window opens.

Back-pressure rules on the request channel:
- A request is taken on a rising edge of `clk` where `req_valid` and `req_ready` are both high.
- `req_ready` stays low from the edge that accepts a request until the result pulse has ended.
- The requester must hold `req_valid` and `req_hz` steady until they are taken.
- The result side has no back-pressure. `res_valid` is a single-cycle pulse, and `res_div` and `res_hz` hold their values until the next result.

Top module: `sck_clkgen`

## Requirements
- R1: After reset, `sck` is 0, `req_ready` is 1, `res_valid` is 0, `res_div` and `res_hz` are 0, and the applied configuration is source 0 with pre-divider code 0.
- R2: Source code s (0..3) selects root SRC0_HZ..SRC3_HZ. Pre-divider code p (0..7) gives the base rate F = floor(root/(p+1)). Each result reports `res_hz` = floor(F/(`res_div`+2)) with `res_valid` high for exactly one cycle.
- R3: For a nonzero request R, `res_div` = ceil(F/R) − 2, clamped to the range 0..255. This is the fastest rate not above R whenever that rate is reachable.
- R4: Any request of at least F/2 gives `res_div` = 0 and `res_hz` = floor(F/2). Different requests that fall into the same rate bucket give identical results.
- R5: Requests so slow that ceil(F/R) − 2 exceeds 255 give `res_div` = 255. With F = 240 MHz this is 933852 Hz.
- R6: A request of 0 Hz gives `res_div` = 255 and `res_hz` = floor(F/257). No divide-by-zero occurs.
- R7: A request equal to the last computed one, with no configuration applied since, produces its result pulse one cycle after acceptance and repeats the cached values.
- R8: Any applied configuration write, including one with unchanged values, invalidates the cache. The next request, even if equal to the previous one, takes the full calculation latency and reflects the new configuration.
- R9: A configuration write made while `sck_en` is high or a calculation is in progress is held, not applied. Of several held writes, the last one is applied once `sck_en` is low and the calculator is idle.
- R10: While `sck_en` is high, `sck` has a period of `res_div`+2 clock cycles, with a high phase of ceil((`res_div`+2)/2) cycles. One cycle after `sck_en` falls, `sck` is 0 and stays 0.
- R11: `req_ready` is low from the accepting edge of a full calculation until its result. A request held during that time is not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; SCK periods are counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | One-cycle strobe writing source and pre-divider |
| cfg_src | input | 2 | Root source code 0..3 |
| cfg_pdiv | input | 3 | Pre-divider code, divides by code+1 |
| sck_en | input | 1 | Runs SCK when high; high also marks a transfer as active |
| req_valid | input | 1 | Rate request present |
| req_ready | output | 1 | Calculator can take a request |
| req_hz | input | 32 | Requested SCK rate in Hz |
| res_valid | output | 1 | One-cycle result pulse |
| res_div | output | 8 | Chosen final divisor N |
| res_hz | output | 32 | Achieved SCK rate in Hz |
| sck | output | 1 | Generated serial clock |

## Verification
The divisor law is driven with random requests over random source and pre-divider codes, in three ranges: near the top rate, in the middle, and very slow. Each range exercises a different branch: clamping to 0, the ordinary ceiling, and saturation at 255. Directed requests on a 240 MHz base cover bucket edges, 0 Hz and the largest 32-bit value, which the random ranges reach only rarely. Repeated requests, separated or not by a configuration write made while idle or while active, show whether the cache and the held-write path differ in latency and in result. SCK periods and high widths measured for even and odd ratios show whether the duty rule is met.

// File: rtl/sck_gen_pkg.sv
package sck_gen_pkg;
  typedef enum logic [2:0] {
    CS_IDLE  = 3'd0,
    CS_LOAD  = 3'd1,
    CS_BASE  = 3'd2,
    CS_RATIO = 3'd3,
    CS_ACH   = 3'd4
  } calc_state_e;
endpackage

// File: rtl/sck_udiv.sv
module sck_udiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dsr_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [W:0]    trial;
  logic          fits;
  logic [W-1:0]  rem_nx;

  always_comb begin
    trial  = {rem_q, quo_q[W-1]};
    fits   = (trial >= {1'b0, dsr_q});
    rem_nx = fits ? W'(trial - {1'b0, dsr_q}) : trial[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= dividend;
        dsr_q <= divisor;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        rem_q <= rem_nx;
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done_q <= 1'b1;
      end
    end
  end

  assign busy = (cnt_q != '0);
  assign done = done_q;
  assign quo  = quo_q;
  assign rem  = rem_q;

  AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R2

  AST_DIV_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R2
endmodule

// File: rtl/sck_cfg_gate.sv
module sck_cfg_gate #(
  parameter int SW = 2,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [SW-1:0] src_in,
  input  logic [PW-1:0] pdiv_in,
  input  logic          idle,
  output logic [SW-1:0] cur_src,
  output logic [PW-1:0] cur_pdiv,
  output logic          apply
);
  logic          pend_q;
  logic [SW-1:0] pend_src_q, cur_src_q;
  logic [PW-1:0] pend_pdiv_q, cur_pdiv_q;

  assign apply = idle && (wr || pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_src_q  <= '0;
      pend_pdiv_q <= '0;
      cur_src_q   <= '0;
      cur_pdiv_q  <= '0;
    end else if (apply) begin
      pend_q     <= 1'b0;
      cur_src_q  <= wr ? src_in  : pend_src_q;
      cur_pdiv_q <= wr ? pdiv_in : pend_pdiv_q;
    end else if (wr) begin
      pend_q      <= 1'b1;
      pend_src_q  <= src_in;
      pend_pdiv_q <= pdiv_in;
    end
  end

  assign cur_src  = cur_src_q;
  assign cur_pdiv = cur_pdiv_q;

  AST_CFG_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_src != $past(cur_src)) || (cur_pdiv != $past(cur_pdiv))) |-> $past(idle)); // R9

  AST_CFG_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr) && !$past(idle)) |-> pend_q); // R9
endmodule

// File: rtl/sck_rate_calc.sv
module sck_rate_calc
  import sck_gen_pkg::*;
#(
  parameter int FW = 32,
  parameter int NW = 8,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [FW-1:0] req_hz,
  input  logic          cfg_apply,
  input  logic [FW-1:0] root_hz,
  input  logic [PW-1:0] pdiv,
  output logic          res_valid,
  output logic [NW-1:0] res_div,
  output logic [FW-1:0] res_hz,
  output logic          busy
);
  localparam logic [NW-1:0] NMAX  = '1;
  localparam int            MW    = NW + 1;
  localparam logic [FW:0]   D_SAT = (FW+1)'(NMAX) + (FW+1)'(2);

  calc_state_e   st_q;
  logic [FW-1:0] req_q, last_req_q, f_q, ach_q;
  logic [NW-1:0] n_q, n_calc;
  logic          cache_ok_q, res_valid_q;
  logic          hit, take;
  logic [FW:0]   d_need;
  logic [MW-1:0] m_calc;

  logic          dv_start, dv_done, dv_busy;
  logic [FW-1:0] dv_dend, dv_dsor, dv_quo, dv_rem;

  sck_udiv #(.W(FW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (dv_start),
    .dividend (dv_dend),
    .divisor  (dv_dsor),
    .busy     (dv_busy),
    .done     (dv_done),
    .quo      (dv_quo),
    .rem      (dv_rem)
  );

  // Ceiling of F/R, turned into N with clamping at both ends.
  always_comb begin
    d_need = {1'b0, dv_quo} + (FW+1)'(dv_rem != '0);
    if (d_need > D_SAT)              n_calc = NMAX;
    else if (d_need < (FW+1)'(2))    n_calc = '0;
    else                             n_calc = NW'(d_need - (FW+1)'(2));
    m_calc = {1'b0, n_calc} + MW'(2);
  end

  always_comb begin
    dv_start = 1'b0;
    dv_dend  = f_q;
    dv_dsor  = FW'(1);
    unique case (st_q)
      CS_LOAD: begin
        dv_start = 1'b1;
        dv_dend  = root_hz;
        dv_dsor  = FW'(pdiv) + FW'(1);
      end
      CS_BASE: begin
        dv_start = dv_done;
        dv_dend  = dv_quo;
        dv_dsor  = (req_q == '0) ? FW'(D_SAT) : req_q;
      end
      CS_RATIO: begin
        dv_start = dv_done;
        dv_dend  = f_q;
        dv_dsor  = FW'(m_calc);
      end
      default: ;
    endcase
  end

  assign req_ready = (st_q == CS_IDLE) && !res_valid_q;
  assign take      = req_valid && req_ready;
  assign hit       = cache_ok_q && !cfg_apply && (req_hz == last_req_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= CS_IDLE;
      req_q       <= '0;
      last_req_q  <= '0;
      f_q         <= '0;
      ach_q       <= '0;
      n_q         <= '0;
      cache_ok_q  <= 1'b0;
      res_valid_q <= 1'b0;
    end else begin
      res_valid_q <= 1'b0;
      if (cfg_apply) cache_ok_q <= 1'b0;
      unique case (st_q)
        CS_IDLE: begin
          if (take) begin
            if (hit) begin
              res_valid_q <= 1'b1;
            end else begin
              req_q <= req_hz;
              st_q  <= CS_LOAD;
            end
          end
        end
        CS_LOAD: st_q <= CS_BASE;
        CS_BASE: begin
          if (dv_done) begin
            f_q <= dv_quo;
            if (req_q == '0) begin
              n_q  <= NMAX;
              st_q <= CS_ACH;
            end else begin
              st_q <= CS_RATIO;
            end
          end
        end
        CS_RATIO: begin
          if (dv_done) begin
            n_q  <= n_calc;
            st_q <= CS_ACH;
          end
        end
        CS_ACH: begin
          if (dv_done) begin
            ach_q       <= dv_quo;
            res_valid_q <= 1'b1;
            last_req_q  <= req_q;
            cache_ok_q  <= 1'b1;
            st_q        <= CS_IDLE;
          end
        end
        default: st_q <= CS_IDLE;
      endcase
    end
  end

  assign res_valid = res_valid_q;
  assign res_div   = n_q;
  assign res_hz    = ach_q;
  assign busy      = (st_q != CS_IDLE);

  AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R2

  AST_ACH_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((64'(res_hz) * 64'({1'b0, res_div} + MW'(2)) <= 64'(f_q)) &&
                   (64'(f_q) < (64'(res_hz) + 64'd1) * 64'({1'b0, res_div} + MW'(2))))); // R2

  AST_NOT_ABOVE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (last_req_q != '0) && (res_div != NMAX)) |-> (res_hz <= last_req_q)); // R3

  AST_FASTEST_CHOICE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_div != '0) && (res_div != NMAX)) |->
      (64'(last_req_q) * 64'({1'b0, res_div} + MW'(1)) < 64'(f_q))); // R3

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take && !hit) |-> !req_ready); // R11
endmodule

// File: rtl/sck_wave.sv
module sck_wave #(
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [NW-1:0] div,
  output logic          sck
);
  localparam int MW = NW + 1;

  logic          run_q;
  logic [MW-1:0] cnt_q, m_q, hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      m_q   <= MW'(2);
    end else begin
      run_q <= en;
      if (!run_q || (cnt_q == m_q - MW'(1))) begin
        cnt_q <= '0;
        m_q   <= {1'b0, div} + MW'(2);
      end else begin
        cnt_q <= cnt_q + MW'(1);
      end
    end
  end

  assign hi  = (m_q + MW'(1)) >> 1;
  assign sck = run_q && (cnt_q < hi);

  AST_SCK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !sck); // R10

  AST_SCK_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < m_q)); // R10
endmodule

// File: rtl/sck_clkgen.sv
module sck_clkgen #(
  parameter int          FW      = 32,
  parameter int          NW      = 8,
  parameter int          SW      = 2,
  parameter int          PW      = 3,
  parameter logic [31:0] SRC0_HZ = 32'd664615384,
  parameter logic [31:0] SRC1_HZ = 32'd720000000,
  parameter logic [31:0] SRC2_HZ = 32'd528000000,
  parameter logic [31:0] SRC3_HZ = 32'd396000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [SW-1:0] cfg_src,
  input  logic [PW-1:0] cfg_pdiv,
  input  logic          sck_en,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [FW-1:0] req_hz,
  output logic          res_valid,
  output logic [NW-1:0] res_div,
  output logic [FW-1:0] res_hz,
  output logic          sck
);
  localparam int NSRC = 1 << SW;

  logic [FW-1:0] src_tab [NSRC];
  logic [SW-1:0] cur_src;
  logic [PW-1:0] cur_pdiv;
  logic          cfg_apply, calc_busy, idle;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam logic [31:0] HZ = (g == 0) ? SRC0_HZ :
                                 (g == 1) ? SRC1_HZ :
                                 (g == 2) ? SRC2_HZ : SRC3_HZ;
    assign src_tab[g] = FW'(HZ);
  end

  assign idle = !sck_en && !calc_busy;

  sck_cfg_gate #(.SW(SW), .PW(PW)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .src_in   (cfg_src),
    .pdiv_in  (cfg_pdiv),
    .idle     (idle),
    .cur_src  (cur_src),
    .cur_pdiv (cur_pdiv),
    .apply    (cfg_apply)
  );

  sck_rate_calc #(.FW(FW), .NW(NW), .PW(PW)) u_calc (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_hz    (req_hz),
    .cfg_apply (cfg_apply),
    .root_hz   (src_tab[cur_src]),
    .pdiv      (cur_pdiv),
    .res_valid (res_valid),
    .res_div   (res_div),
    .res_hz    (res_hz),
    .busy      (calc_busy)
  );

  sck_wave #(.NW(NW)) u_wave (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (sck_en),
    .div   (res_div),
    .sck   (sck)
  );

  AST_NO_CFG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_busy || sck_en) |-> !cfg_apply); // R9
endmodule

// File: tb/test_sck_clkgen.sv
module test_sck_clkgen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_src = '0;
  logic [2:0]  cfg_pdiv = '0;
  logic        sck_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_hz = '0;
  logic        res_valid;
  logic [7:0]  res_div;
  logic [31:0] res_hz;
  logic        sck;

  int total = 0;
  int bad = 0;
  int m_src = 0;
  int m_pdiv = 0;
  int lat;
  logic busy_seen_ready;

  always #(CLK_PERIOD/2) clk = ~clk;

  sck_clkgen i_sck_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_src   (cfg_src),
    .cfg_pdiv  (cfg_pdiv),
    .sck_en    (sck_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_hz    (req_hz),
    .res_valid (res_valid),
    .res_div   (res_div),
    .res_hz    (res_hz),
    .sck       (sck)
  );

  function automatic longint root_of(int s);
    case (s)
      0: return 64'd664615384;
      1: return 64'd720000000;
      2: return 64'd528000000;
      default: return 64'd396000000;
    endcase
  endfunction

  function automatic longint base_f(int s, int p);
    return root_of(s) / (p + 1);
  endfunction

  function automatic longint exp_n(longint f, longint r);
    longint d;
    if (r == 0) return 255;
    d = (f + r - 1) / r;
    if (d < 2) return 0;
    if (d - 2 > 255) return 255;
    return d - 2;
  endfunction

  task automatic chk(input string tag, input longint act, input longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic write_cfg(input int s, input int p);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_src = 2'(s); cfg_pdiv = 3'(p);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_req(input longint r);
    @(negedge clk);
    req_valid = 1'b1; req_hz = 32'(r);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen_ready = req_ready;
    lat = 1;
    while (!res_valid && lat < 500) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_req(input string tag, input longint r);
    longint f, n;
    f = base_f(m_src, m_pdiv);
    n = exp_n(f, r);
    do_req(r);
    chk({tag, " res_valid"}, res_valid, 1);
    chk({tag, " divisor"}, res_div, n);
    chk({tag, " rate"}, res_hz, f / (n + 2));
  endtask

  task automatic measure(output int per, output int hi);
    logic prev;
    int guard;
    prev = sck; guard = 0;
    @(negedge clk);
    while (!(!prev && sck) && guard < 2000) begin
      prev = sck; @(negedge clk); guard++;
    end
    per = 1; hi = 1; prev = 1'b1;
    forever begin
      @(negedge clk);
      if (!prev && sck) break;
      if (sck) hi++;
      per++;
      prev = sck;
      if (per > 2000) break;
    end
  endtask

  task automatic check_sck(input string tag, input longint r);
    int per, hi, m;
    check_req(tag, r);
    m = int'(res_div) + 2;
    @(negedge clk); sck_en = 1'b1;
    measure(per, hi);
    chk({tag, " R10 sck period"}, per, m);
    chk({tag, " R10 sck high"}, hi, (m + 1) / 2);
    @(negedge clk); sck_en = 1'b0;
    @(negedge clk);
    chk({tag, " R10 sck gated"}, sck, 0);
    repeat (4) @(negedge clk);
    chk({tag, " R10 sck stays low"}, sck, 0);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint r, f, held_n, held_hz;
    int s, p, sel;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sck", sck, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 res_div", res_div, 0);
    chk("R1 res_hz", res_hz, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", req_ready, 1);
    // R1 default config source 0, pdiv 0
    check_req("R1 default cfg", 64'd50000000);

    // Directed on F = 240 MHz
    write_cfg(1, 2); m_src = 1; m_pdiv = 2;
    check_req("R4 exact top", 64'd120000000);
    check_req("R4 max word", 64'd4294967295);
    check_req("R3 90M", 64'd90000000);
    chk("R11 ready low while busy", busy_seen_ready, 0);
    check_req("R4 110M same bucket", 64'd110000000);
    chk("R4 bucket rate", res_hz, 80000000);
    check_req("R3 60M", 64'd60000000);
    check_req("R5 1Hz", 64'd1);
    chk("R5 slowest", res_hz, 933852);
    check_req("R6 zero", 64'd0);
    check_req("R3 slow edge", 64'd933852);
    check_req("R5 below edge", 64'd933851);

    // R7 cache hit
    check_req("R3 48M", 64'd48000000);
    do_req(64'd48000000);
    chk("R7 cached latency", lat, 1);
    chk("R7 cached divisor", res_div, 3);
    chk("R7 cached rate", res_hz, 48000000);

    // R8 same config rewrite invalidates
    write_cfg(1, 2);
    check_req("R8 recompute", 64'd48000000);
    chk("R8 full latency", (lat > 2) ? 1 : 0, 1);

    // R9 held writes while active
    @(negedge clk); sck_en = 1'b1;
    write_cfg(2, 0);
    write_cfg(3, 7);
    held_n = res_div; held_hz = res_hz;
    do_req(64'd48000000);
    chk("R9 no apply while active latency", lat, 1);
    chk("R9 no apply divisor", res_div, held_n);
    chk("R9 no apply rate", res_hz, held_hz);
    @(negedge clk); sck_en = 1'b0;
    repeat (2) @(negedge clk);
    m_src = 3; m_pdiv = 7;
    check_req("R9 last write applied", 64'd48000000);
    chk("R8 after held apply latency", (lat > 2) ? 1 : 0, 1);

    // R10 waveform, even and odd ratios
    write_cfg(1, 2); m_src = 1; m_pdiv = 2;
    check_sck("ratio2", 64'd200000000);
    check_sck("ratio3", 64'd80000000);
    check_sck("ratio6", 64'd40000000);
    check_sck("ratio7", 64'd34285715);
    check_sck("ratio257", 64'd0);

    // Random sweep
    for (int i = 0; i < 180; i++) begin
      s = int'($urandom % 4);
      p = int'($urandom % 8);
      write_cfg(s, p); m_src = s; m_pdiv = p;
      f = base_f(s, p);
      sel = int'($urandom % 3);
      if (sel == 0)      r = longint'($urandom % 32'd400000000) + f / 4;
      else if (sel == 1) r = longint'($urandom % 32'd60000000) + 1;
      else               r = longint'($urandom % 32'd3000000);
      check_req("R2 R3 random", r);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule